// File: doc/BRIEF.md
# Thermometer scratchpad with alarm flag

This block is the function-command layer of a single-wire temperature slave. A byte-level link below it has already done slot timing and ROM selection; it hands over received bytes (`rx_valid`/`rx_data`), pulses `link_reset` on every bus reset, and asks for outgoing bytes with `tx_req`. The block keeps a nine-byte scratchpad: the temperature word, two alarm limit bytes, two reserved bytes, a residual count, a fixed counts-per-degree byte and a CRC. It runs conversions, copies and recalls against a nonvolatile backing pair, each timed by a shared busy counter.

A conversion latches the sensor word from `sense_temp` and the residual count from `sense_remain` when its timer expires. It then re-evaluates `alarm_flag`, which the ROM layer uses to decide whether the device joins an alarm search. The high limit sits in byte 2 and the low limit in byte 3. Both are signed whole degrees and are compared against bits 8:1 of the temperature.

Top module: `thermo_pad`

## Requirements
- R1: After reset the temperature word is 00AAh, the residual count is 0Ch, the high/low limits equal the nonvolatile initial values (parameters, default 4Bh/46h), and `alarm_flag` is 0.
- R2: The first byte after `link_reset` is taken as a command only while `addressed` is 1. The codes are 44h convert, 4Eh write limits, BEh read, 48h copy and B8h recall. Any other code, and any byte that follows a command other than write data, has no effect until the next `link_reset`.
- R3: Each `tx_req` pulse yields one byte, with `tx_valid` high, on the following cycle. After a BEh command the bytes come out in index order 0 to 8, and any byte beyond index 8 is FFh. Outside a read or recall every byte is FFh, and `link_reset` ends a read.
- R4: Byte 0 holds temperature bits 7:0 and byte 1 holds bits 15:8. Bytes 4 and 5 read FFh, byte 6 holds the residual count and byte 7 holds 10h.
- R5: Byte 8 is the CRC-8 of bytes 0 to 7, computed when the byte is read. The polynomial is x^8+x^5+x^4+1, bits are taken LSB first and the register starts at zero. For the reset contents the CRC is 87h.
- R6: A convert command starts a conversion of CONV_CYCLES cycles. When it ends, the temperature and residual count take the values on `sense_temp` and `sense_remain`, and they change at no other time.
- R7: At the end of each conversion, `alarm_flag` becomes 1 if new temperature bits 8:1, read as a signed value, are greater than the signed high limit or less than the signed low limit, and 0 otherwise. It changes at no other time.
- R8: A 4Eh command takes two data bytes, high limit then low limit, and applies both together on the second byte. A `link_reset` after only one data byte leaves both limits unchanged.
- R9: A 48h command copies both limits into the nonvolatile pair once COPY_CYCLES cycles have passed.
- R10: A B8h command reloads both limits from the nonvolatile pair once RCL_CYCLES cycles have passed. Each `tx_req` in that transaction returns 00h while the reload is pending and FFh once it is done.
- R11: A command byte that arrives while a conversion, copy or recall is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| link_reset | input | 1 | One-cycle pulse on a bus reset |
| addressed | input | 1 | ROM selection passed for this transaction |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Request for one outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid, one cycle after the request |
| tx_data | output | 8 | Outgoing byte |
| sense_temp | input | 16 | Sensor temperature word, half-degree two's complement |
| sense_remain | input | 8 | Sensor residual count |
| alarm_flag | output | 1 | Alarm condition from the latest conversion |

## Verification
The assertions assume the link never raises `rx_valid` and `tx_req` in the same cycle, and that `link_reset` is a single-cycle pulse. Under those assumptions, the temperature word and alarm flag move only at a conversion end, and the limit pair moves only on a completed write or a finished recall. The stimulus issues one byte action per task, with idle cycles between them. It waits out each timed command before starting the next, except in the deliberate overlap case, where a command is sent into a running conversion.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  typedef enum logic [2:0] {
    PH_CMD, PH_WR_HI, PH_WR_LO, PH_READ, PH_RECALL, PH_IDLE
  } phase_t;

  typedef enum logic [1:0] {
    JOB_NONE, JOB_CONV, JOB_COPY, JOB_RCL
  } job_t;

  localparam logic [7:0] OP_CONVERT = 8'h44;
  localparam logic [7:0] OP_WRITE   = 8'h4E;
  localparam logic [7:0] OP_READ    = 8'hBE;
  localparam logic [7:0] OP_COPY    = 8'h48;
  localparam logic [7:0] OP_RECALL  = 8'hB8;

  // one byte through the reflected x^8+x^5+x^4+1 register, LSB first
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] data);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  // whole-degree part (bits 8:1) against signed limits
  function automatic logic alarm_check(input logic [15:0] t, input logic [7:0] hi, input logic [7:0] lo);
    logic signed [7:0] deg;
    deg = t[8:1];
    return (deg > $signed(hi)) || (deg < $signed(lo));
  endfunction

endpackage

// File: rtl/tp_timer.sv
module tp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         busy,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= len;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == W'(1));
endmodule

// File: rtl/tp_padread.sv
module tp_padread #(
  parameter logic [7:0] PER_DEG = 8'h10
) (
  input  logic [15:0] temp,
  input  logic [7:0]  th,
  input  logic [7:0]  tl,
  input  logic [7:0]  remain,
  input  logic [3:0]  idx,
  output logic [7:0]  pad_byte
);
  localparam int DATA_BYTES = 8;

  logic [7:0] bytes [DATA_BYTES];
  logic [7:0] crc;

  assign bytes[0] = temp[7:0];
  assign bytes[1] = temp[15:8];
  assign bytes[2] = th;
  assign bytes[3] = tl;
  assign bytes[6] = remain;
  assign bytes[7] = PER_DEG;

  genvar g;
  generate
    for (g = 4; g < 6; g++) begin : g_rsvd
      assign bytes[g] = 8'hFF;
    end
  endgenerate

  always_comb begin
    crc = 8'h00;
    for (int i = 0; i < DATA_BYTES; i++) crc = thermo_pkg::crc8_byte(crc, bytes[i]);
  end

  always_comb begin
    if (idx < 4'(DATA_BYTES))       pad_byte = bytes[idx[2:0]];
    else if (idx == 4'(DATA_BYTES)) pad_byte = crc;
    else                            pad_byte = 8'hFF;
  end
endmodule

// File: rtl/thermo_pad.sv
module thermo_pad
  import thermo_pkg::*;
#(
  parameter int         CONV_CYCLES = 750000,
  parameter int         COPY_CYCLES = 10000,
  parameter int         RCL_CYCLES  = 16,
  parameter logic [7:0] NV_HI_INIT  = 8'h4B,
  parameter logic [7:0] NV_LO_INIT  = 8'h46
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_reset,
  input  logic        addressed,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        tx_req,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic [15:0] sense_temp,
  input  logic [7:0]  sense_remain,
  output logic        alarm_flag
);
  localparam int LONG_A  = (CONV_CYCLES > COPY_CYCLES) ? CONV_CYCLES : COPY_CYCLES;
  localparam int LONGEST = (LONG_A > RCL_CYCLES) ? LONG_A : RCL_CYCLES;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam logic [3:0] IDX_END = 4'd9;

  phase_t      phase, next_phase;
  job_t        job, start_job;
  logic [15:0] temp;
  logic [7:0]  remain, th, tl, nv_hi, nv_lo, hold, pad_byte, out_byte;
  logic [3:0]  rd_idx;
  logic [TW-1:0] start_len;
  logic        t_busy, t_done, start;

  // named internal events
  logic cmd_take, wr_commit, conv_done, copy_done, rcl_done, in_cmd;

  assign in_cmd    = (phase == PH_CMD);
  assign cmd_take  = rx_valid && !link_reset && in_cmd && addressed;
  assign wr_commit = rx_valid && !link_reset && (phase == PH_WR_LO);
  assign conv_done = t_done && (job == JOB_CONV);
  assign copy_done = t_done && (job == JOB_COPY);
  assign rcl_done  = t_done && (job == JOB_RCL);
  assign start     = cmd_take && !t_busy && (start_job != JOB_NONE);

  always_comb begin
    start_job  = JOB_NONE;
    start_len  = '0;
    next_phase = PH_IDLE;
    if (!t_busy) begin
      unique case (rx_data)
        OP_CONVERT: begin start_job = JOB_CONV; start_len = TW'(CONV_CYCLES); end
        OP_COPY:    begin start_job = JOB_COPY; start_len = TW'(COPY_CYCLES); end
        OP_RECALL:  begin start_job = JOB_RCL;  start_len = TW'(RCL_CYCLES);  next_phase = PH_RECALL; end
        OP_WRITE:   next_phase = PH_WR_HI;
        OP_READ:    next_phase = PH_READ;
        default:    next_phase = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_READ:   out_byte = pad_byte;
      PH_RECALL: out_byte = t_busy ? 8'h00 : 8'hFF;
      default:   out_byte = 8'hFF;
    endcase
  end

  tp_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .len(start_len),
    .busy(t_busy), .done(t_done)
  );

  tp_padread u_pad (
    .temp(temp), .th(th), .tl(tl), .remain(remain), .idx(rd_idx), .pad_byte(pad_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      job        <= JOB_NONE;
      temp       <= 16'h00AA;
      remain     <= 8'h0C;
      th         <= NV_HI_INIT;
      tl         <= NV_LO_INIT;
      nv_hi      <= NV_HI_INIT;
      nv_lo      <= NV_LO_INIT;
      hold       <= 8'h00;
      rd_idx     <= 4'd0;
      alarm_flag <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= 8'hFF;
    end else begin
      tx_valid <= 1'b0;
      if (conv_done) begin
        temp       <= sense_temp;
        remain     <= sense_remain;
        alarm_flag <= alarm_check(sense_temp, th, tl);
      end
      if (copy_done) begin
        nv_hi <= th;
        nv_lo <= tl;
      end
      if (rcl_done) begin
        th <= nv_hi;
        tl <= nv_lo;
      end
      if (wr_commit) begin
        th <= hold;
        tl <= rx_data;
      end
      if (start) job <= start_job;
      if (link_reset) begin
        phase <= PH_CMD;
      end else if (rx_valid) begin
        case (phase)
          PH_CMD:   if (addressed) begin phase <= next_phase; rd_idx <= 4'd0; end
          PH_WR_HI: begin hold <= rx_data; phase <= PH_WR_LO; end
          PH_WR_LO: phase <= PH_IDLE;
          default:  ;
        endcase
      end else if (tx_req) begin
        tx_valid <= 1'b1;
        tx_data  <= out_byte;
        if (phase == PH_READ && rd_idx != IDX_END) rd_idx <= rd_idx + 4'd1;
      end
    end
  end
endmodule

// File: rtl/thermo_pad_chk.sv
module thermo_pad_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        link_reset,
  input logic        tx_req,
  input logic        tx_valid,
  input logic        alarm_flag,
  input logic [15:0] temp,
  input logic [7:0]  th,
  input logic [7:0]  tl,
  input logic        conv_done,
  input logic        wr_commit,
  input logic        rcl_done,
  input logic        in_cmd
);
  assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));

  assert_reset_to_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset |=> in_cmd);

  assert_temp_only_on_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(temp));

  assert_alarm_only_on_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(alarm_flag));

  assert_limits_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit || rcl_done) |=> $stable({th, tl}));
endmodule

bind thermo_pad thermo_pad_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .tx_req(tx_req),
  .tx_valid(tx_valid), .alarm_flag(alarm_flag), .temp(temp), .th(th), .tl(tl),
  .conv_done(conv_done), .wr_commit(wr_commit), .rcl_done(rcl_done), .in_cmd(in_cmd)
);

// File: tb/sim_thermo_pad.sv
module sim_thermo_pad;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 20;
  localparam int COPY = 12;
  localparam int RCL  = 6;
  localparam logic [7:0] NVH = 8'h4B;
  localparam logic [7:0] NVL = 8'h46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_reset = 1'b0, addressed = 1'b1, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [15:0] sense_temp = 16'h0000;
  logic [7:0] sense_remain = 8'h00;
  logic tx_valid, alarm_flag;
  logic [7:0] tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_pad #(.CONV_CYCLES(CONV), .COPY_CYCLES(COPY), .RCL_CYCLES(RCL),
               .NV_HI_INIT(NVH), .NV_LO_INIT(NVL)) u0 (
    .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .addressed(addressed),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req), .tx_valid(tx_valid),
    .tx_data(tx_data), .sense_temp(sense_temp), .sense_remain(sense_remain),
    .alarm_flag(alarm_flag)
  );

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit finished = 0;

  // ---------------- behavioural reference ----------------
  // mode: 0 wait-cmd, 1 first data, 2 second data, 3 read, 4 recall, 5 idle
  int m_mode, m_idx, m_left, m_job;
  logic [15:0] m_temp;
  logic [7:0] m_rem, m_th, m_tl, m_nvh, m_nvl, m_buf, m_txd;
  logic m_txv, m_alarm;

  function automatic logic [7:0] ref_crc(input logic [7:0] d [8]);
    logic [7:0] r = 0;
    for (int k = 0; k < 64; k++) begin
      logic b = d[k/8][k%8];
      if (r[0] ^ b) r = (r >> 1) ^ 8'h8C; else r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_byte(input int n);
    logic [7:0] d [8];
    d[0] = m_temp[7:0]; d[1] = m_temp[15:8]; d[2] = m_th; d[3] = m_tl;
    d[4] = 8'hFF; d[5] = 8'hFF; d[6] = m_rem; d[7] = 8'h10;
    if (n < 8) return d[n];
    if (n == 8) return ref_crc(d);
    return 8'hFF;
  endfunction

  function automatic logic ref_alarm(input logic [15:0] t, input logic [7:0] h, input logic [7:0] l);
    int deg = $signed(t) >>> 1;
    return (deg > int'($signed(h))) || (deg < int'($signed(l)));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_idx <= 0; m_left <= 0; m_job <= 0;
      m_temp <= 16'h00AA; m_rem <= 8'h0C; m_th <= NVH; m_tl <= NVL;
      m_nvh <= NVH; m_nvl <= NVL; m_buf <= 0; m_alarm <= 0; m_txv <= 0; m_txd <= 8'hFF;
    end else begin
      m_txv <= 0;
      if (m_left > 0) begin
        if (m_left == 1) begin
          if (m_job == 1) begin
            m_temp <= sense_temp; m_rem <= sense_remain;
            m_alarm <= ref_alarm(sense_temp, m_th, m_tl);
          end else if (m_job == 2) begin
            m_nvh <= m_th; m_nvl <= m_tl;
          end else if (m_job == 3) begin
            m_th <= m_nvh; m_tl <= m_nvl;
          end
        end
        m_left <= m_left - 1;
      end
      if (link_reset) m_mode <= 0;
      else if (rx_valid) begin
        if (m_mode == 0 && addressed) begin
          m_idx <= 0;
          m_mode <= 5;
          if (m_left == 0) begin
            if (rx_data == 8'h44) begin m_left <= CONV; m_job <= 1; end
            else if (rx_data == 8'h48) begin m_left <= COPY; m_job <= 2; end
            else if (rx_data == 8'hB8) begin m_left <= RCL; m_job <= 3; m_mode <= 4; end
            else if (rx_data == 8'h4E) m_mode <= 1;
            else if (rx_data == 8'hBE) m_mode <= 3;
          end
        end else if (m_mode == 1) begin m_buf <= rx_data; m_mode <= 2; end
        else if (m_mode == 2) begin m_th <= m_buf; m_tl <= rx_data; m_mode <= 5; end
      end else if (tx_req) begin
        m_txv <= 1;
        if (m_mode == 3) begin
          m_txd <= ref_byte(m_idx);
          if (m_idx < 9) m_idx <= m_idx + 1;
        end else if (m_mode == 4) m_txd <= (m_left > 0) ? 8'h00 : 8'hFF;
        else m_txd <= 8'hFF;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (tx_valid !== m_txv || (m_txv && tx_data !== m_txd) || alarm_flag !== m_alarm) begin
        mismatched++;
        $display("FAIL %s: valid/data/alarm got %b/%02h/%b expected %b/%02h/%b",
                 cur_req, tx_valid, tx_data, alarm_flag, m_txv, m_txd, m_alarm);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic expect8(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic lreset();
    link_reset = 1; @(negedge clk); link_reset = 0; @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0; @(negedge clk);
  endtask

  task automatic get(output logic [7:0] b);
    tx_req = 1; @(negedge clk); tx_req = 0; b = tx_data; @(negedge clk);
  endtask

  logic [7:0] pad [10];

  task automatic read_all();
    lreset(); send(8'hBE);
    for (int i = 0; i < 10; i++) get(pad[i]);
  endtask

  task automatic convert(input logic [15:0] t, input logic [7:0] r);
    sense_temp = t; sense_remain = r;
    lreset(); send(8'h44);
    repeat (CONV + 3) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1; mismatched++; compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    compared++; if (alarm_flag !== 1'b0 || tx_valid !== 1'b0) begin
      mismatched++; $display("FAIL R1: alarm/valid got %b/%b expected 0/0", alarm_flag, tx_valid);
    end
    cur_req = "R3";
    read_all();
    expect8("R1", {pad[1], pad[0]} == 16'h00AA ? 8'h01 : 8'h00, 8'h01);
    expect8("R1", pad[2], NVH);
    expect8("R1", pad[3], NVL);
    expect8("R4", pad[4], 8'hFF);
    expect8("R4", pad[5], 8'hFF);
    expect8("R1", pad[6], 8'h0C);
    expect8("R4", pad[7], 8'h10);
    expect8("R5", pad[8], 8'h87);
    expect8("R3", pad[9], 8'hFF);

    // R8 full write
    cur_req = "R8";
    lreset(); send(8'h4E); send(8'h19); send(8'hF6);
    read_all();
    expect8("R8", pad[2], 8'h19);
    expect8("R8", pad[3], 8'hF6);
    // R8 partial write then reset
    lreset(); send(8'h4E); send(8'h30); lreset();
    read_all();
    expect8("R8", pad[2], 8'h19);
    expect8("R8", pad[3], 8'hF6);

    // R6 / R7 conversions, limits +25 / -10
    cur_req = "R6";
    convert(16'h0032, 8'h05);
    read_all();
    expect8("R6", pad[0], 8'h32);
    expect8("R6", pad[6], 8'h05);
    cur_req = "R7";
    expect8("R7", {7'd0, alarm_flag}, 8'h00);   // equal to high limit: no alarm
    convert(16'h0034, 8'h07);
    expect8("R7", {7'd0, alarm_flag}, 8'h01);   // +26 above high
    convert(16'h0000, 8'h0C);
    expect8("R7", {7'd0, alarm_flag}, 8'h00);   // clears
    convert(16'hFFCE, 8'h0C);
    expect8("R7", {7'd0, alarm_flag}, 8'h01);   // -25 below low
    convert(16'hFFEC, 8'h0C);
    expect8("R7", {7'd0, alarm_flag}, 8'h00);   // -10 equal to low
    read_all();
    expect8("R6", pad[1], 8'hFF);
    expect8("R5", pad[8], m_txd == m_txd ? ref_byte(8) : 8'h00);

    // R2 not addressed, unknown code, trailing bytes
    cur_req = "R2";
    addressed = 0;
    lreset(); send(8'h4E); send(8'h00); send(8'h00);
    addressed = 1;
    lreset(); send(8'h12); send(8'hBE); get(b);
    expect8("R2", b, 8'hFF);
    read_all();
    expect8("R2", pad[2], 8'h19);
    expect8("R2", pad[3], 8'hF6);
    lreset(); send(8'hBE); get(b); lreset(); get(b);
    expect8("R3", b, 8'hFF);

    // R9 / R10 copy, overwrite, recall
    cur_req = "R9";
    lreset(); send(8'h4E); send(8'h55); send(8'hAA);
    lreset(); send(8'h48);
    repeat (COPY + 3) @(negedge clk);
    lreset(); send(8'h4E); send(8'h01); send(8'h02);
    cur_req = "R10";
    lreset(); send(8'hB8); get(b);
    expect8("R10", b, 8'h00);
    repeat (RCL + 2) @(negedge clk);
    get(b);
    expect8("R10", b, 8'hFF);
    read_all();
    expect8("R9", pad[2], 8'h55);
    expect8("R10", pad[3], 8'hAA);

    // R11 command during a conversion
    cur_req = "R11";
    sense_temp = 16'h0010;
    lreset(); send(8'h44);
    lreset(); send(8'hBE); get(b);
    expect8("R11", b, 8'hFF);
    repeat (CONV + 3) @(negedge clk);
    read_all();
    expect8("R11", pad[0], 8'h10);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule